// File: doc/BRIEF.md
# External Interrupt Sense and Status

This block takes four asynchronous external interrupt request pins and turns each into a latched request flag. Every pin has its own 2-bit sense field. The field selects one of four modes: low level, falling edge, rising edge, or both edges. Each pin passes through a two-flop synchronizer. Edge detection compares the synchronized sample with the sample taken one cycle earlier.

A small synchronous register port gives access to two registers. The sense-control register holds the mode fields. The 16-bit status word shows two things: the live synchronized pin levels, which are read-only, and the latched flags, which software clears by writing zero. Each flag drives one request line toward a downstream priority controller.

If a detection event falls in the same cycle as a clearing write, the event wins. In low-level mode the flag is re-set on every cycle the pin stays low.

Top module: `ext_irq_sense`

## Requirements
- R1: The control register (`sel_status_i` = 0) holds pin i's sense field in bits [2i+1:2i], so pin 0 uses bits 1:0 and pin 3 uses bits 7:6. All fields reset to 00. Bits 15:8 read 0, and a write stores only bits 7:0.
- R2: Sense code 00 (low level) sets the flag on every cycle the synchronized pin is low. A clearing write while the pin is still low leaves the flag set.
- R3: Sense code 01 (falling edge) sets the flag only when the synchronized pin goes from 1 to 0.
- R4: Sense code 10 (rising edge) sets the flag only when the synchronized pin goes from 0 to 1.
- R5: Sense code 11 sets the flag on either transition of the synchronized pin.
- R6: The status word (`sel_status_i` = 1) has this layout: bits 15:12 read 1111, bits 11:8 hold the levels of pins 3..0 (pin i in bit 8+i), bits 7:4 read 0, and bits 3:0 hold the flags of pins 3..0 (pin i in bit i).
- R7: A level bit shows its pin two clocks after the pin changes. This holds during reset as well, so right after reset each level bit shows the actual pin level.
- R8: Writing 0 to flag bit i of the status word clears that flag. Writing 1 has no effect. A write to the control register leaves the flags untouched.
- R9: A detection event in the same cycle as a clearing write wins, and the flag stays 1.
- R10: Changing a sense field neither sets nor clears a flag by itself. The edge history keeps following the pin in every mode, so an old transition does not raise a flag after a switch to edge mode.
- R11: Reset clears all flags. `irq_req_o[i]` always equals flag i.
- R12: In the edge modes, a pin change driven before clock edge k shows up in the flag after clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_pin_i | input | 4 | Asynchronous external request pins |
| wr_en_i | input | 1 | Single-cycle write strobe |
| sel_status_i | input | 1 | Register select: 0 control, 1 status |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the selected register (combinational) |
| irq_req_o | output | 4 | Per-pin request lines, equal to the flags |

## Verification
The bench goes after these corner cases, and each one catches a specific design error:
- A clear write lands in exactly the cycle a fresh edge is detected. A design that let the clear take priority would drop that interrupt.
- A clear is attempted while a low-level pin is still low. A flag that stayed cleared would lose a level request that is still pending.
- The mode is switched after the pin has already moved. If the history register froze in level mode, a stale transition would raise a phantom flag. If the mode write touched the flags, a pending request would vanish.
- The flag is timed against the synchronizer. A missing or extra stage would show the level or the flag one clock early or late.
- Level bits are read during reset. A synchronizer held in reset would report a fixed value instead of the pin.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    localparam int NUM_PINS  = 4;
    localparam int SENSE_W   = 2;
    localparam int DATA_W    = 16;
    localparam int FLAG_LSB  = 0;
    localparam int LEVEL_LSB = 8;
    localparam int ONES_LSB  = 12;
    localparam int ONES_W    = DATA_W - ONES_LSB;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_BOTH = 2'b11
    } sense_mode_e;

    typedef struct packed {
        logic now;
        logic prev;
    } pin_hist_t;

    // Detection decision for one pin in one cycle
    function automatic logic sense_hit(sense_mode_e mode, pin_hist_t h);
        logic hit;
        case (mode)
            SENSE_LOW:  hit = ~h.now;
            SENSE_FALL: hit = h.prev & ~h.now;
            SENSE_RISE: hit = ~h.prev & h.now;
            default:    hit = h.prev ^ h.now;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int NPINS  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] lvl_o
);

    // Synchronizer flops are not reset so that levels stay live during reset
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [STAGES-1:0] shift_q;
        always_ff @(posedge clk) begin
            shift_q <= {shift_q[STAGES-2:0], pin_i[p]};
        end
        assign lvl_o[p] = shift_q[STAGES-1];
    end

    if (STAGES == 2) begin : g_chk
        // R7
        level_delay_chk: assert property (@(posedge clk) disable iff (rst)
            lvl_o == $past(pin_i, 2));
    end

endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import irq_sense_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lvl_i,
    input  sense_mode_e mode_i,
    input  logic        clr_i,
    output logic        flag_o
);

    logic      prev_q;
    pin_hist_t hist;
    logic      evt;

    // History follows the pin in every mode
    always_ff @(posedge clk) begin
        prev_q <= lvl_i;
    end

    assign hist = '{now: lvl_i, prev: prev_q};
    assign evt  = sense_hit(mode_i, hist);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (evt) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    // R9
    event_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        evt |=> flag_o);

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !evt) |=> !flag_o);

    // R10
    no_spurious_change_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt && !clr_i) |=> $stable(flag_o));

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_sense_pkg::*;
#(
    parameter int NPINS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en_i,
    input  logic                     sel_status_i,
    input  logic [DATA_W-1:0]        wdata_i,
    input  logic [NPINS-1:0]         lvl_i,
    input  logic [NPINS-1:0]         flag_i,
    output logic [SENSE_W*NPINS-1:0] ctrl_o,
    output logic [NPINS-1:0]         clr_o,
    output logic [DATA_W-1:0]        rdata_o
);

    localparam int CTRL_W = SENSE_W * NPINS;

    logic wr_ctrl;
    logic wr_stat;
    logic unused_wbits;

    assign wr_ctrl      = wr_en_i & ~sel_status_i;
    assign wr_stat      = wr_en_i & sel_status_i;
    assign unused_wbits = ^wdata_i[DATA_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_o <= '0;
        end else if (wr_ctrl) begin
            ctrl_o <= wdata_i[CTRL_W-1:0];
        end
    end

    // Clear requests: a zero written into a flag position
    for (genvar p = 0; p < NPINS; p++) begin : g_clr
        assign clr_o[p] = wr_stat & ~wdata_i[FLAG_LSB + p];
    end

    always_comb begin
        rdata_o = '0;
        if (sel_status_i) begin
            rdata_o[DATA_W-1:ONES_LSB] = {ONES_W{1'b1}};
            for (int p = 0; p < NPINS; p++) begin
                rdata_o[LEVEL_LSB + p] = lvl_i[p];
                rdata_o[FLAG_LSB + p]  = flag_i[p];
            end
        end else begin
            rdata_o[CTRL_W-1:0] = ctrl_o;
        end
    end

    // R1
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl_o));

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import irq_sense_pkg::*;
#(
    parameter int NPINS = NUM_PINS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NPINS-1:0]  irq_pin_i,
    input  logic              wr_en_i,
    input  logic              sel_status_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [NPINS-1:0]  irq_req_o
);

    localparam int CTRL_W = SENSE_W * NPINS;

    logic [NPINS-1:0]  lvl;
    logic [NPINS-1:0]  flags;
    logic [NPINS-1:0]  clr;
    logic [CTRL_W-1:0] ctrl;

    irq_pin_sync #(.NPINS(NPINS), .STAGES(2)) i_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (irq_pin_i),
        .lvl_o (lvl)
    );

    irq_regs #(.NPINS(NPINS)) i_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en_i      (wr_en_i),
        .sel_status_i (sel_status_i),
        .wdata_i      (wdata_i),
        .lvl_i        (lvl),
        .flag_i       (flags),
        .ctrl_o       (ctrl),
        .clr_o        (clr),
        .rdata_o      (rdata_o)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_cell
        irq_flag_cell i_cell (
            .clk    (clk),
            .rst    (rst),
            .lvl_i  (lvl[p]),
            .mode_i (sense_mode_e'(ctrl[SENSE_W*p +: SENSE_W])),
            .clr_i  (clr[p]),
            .flag_o (flags[p])
        );
    end

    assign irq_req_o = flags;

    // R11
    req_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        sel_status_i |-> (rdata_o[FLAG_LSB +: NPINS] == irq_req_o));

    // R6
    status_frame_chk: assert property (@(posedge clk) disable iff (rst)
        sel_status_i |-> (rdata_o[DATA_W-1:ONES_LSB] == {ONES_W{1'b1}}));

endmodule

// File: tb/test_ext_irq_sense.sv
`timescale 1ns/1ps
module test_ext_irq_sense;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  pins;
    logic        wr_en;
    logic        sel;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [3:0]  req;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    ext_irq_sense i_ext_irq_sense (
        .clk          (clk),
        .rst          (rst),
        .irq_pin_i    (pins),
        .wr_en_i      (wr_en),
        .sel_status_i (sel),
        .wdata_i      (wdata),
        .rdata_o      (rdata),
        .irq_req_o    (req)
    );

    // {mode[1:0], start level, end level, expected flag}
    localparam logic [4:0] VEC [16] = '{
        {2'b00, 1'b1, 1'b0, 1'b1}, {2'b00, 1'b0, 1'b1, 1'b1},
        {2'b00, 1'b1, 1'b1, 1'b0}, {2'b00, 1'b0, 1'b0, 1'b1},
        {2'b01, 1'b1, 1'b0, 1'b1}, {2'b01, 1'b0, 1'b1, 1'b0},
        {2'b01, 1'b1, 1'b1, 1'b0}, {2'b01, 1'b0, 1'b0, 1'b0},
        {2'b10, 1'b1, 1'b0, 1'b0}, {2'b10, 1'b0, 1'b1, 1'b1},
        {2'b10, 1'b1, 1'b1, 1'b0}, {2'b10, 1'b0, 1'b0, 1'b0},
        {2'b11, 1'b1, 1'b0, 1'b1}, {2'b11, 1'b0, 1'b1, 1'b1},
        {2'b11, 1'b1, 1'b1, 1'b0}, {2'b11, 1'b0, 1'b0, 1'b0}
    };

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req_tag, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
        end
    endtask

    task automatic reg_write(logic to_status, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        sel   = to_status;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        sel   = 1'b1;
        wdata = '0;
    endtask

    task automatic read_status(output logic [15:0] v);
        sel = 1'b1;
        #1 v = rdata;
    endtask

    task automatic read_ctrl(output logic [15:0] v);
        sel = 1'b0;
        #1 v = rdata;
        sel = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] v;
        rst   = 1'b1;
        pins  = 4'b0111;
        wr_en = 1'b0;
        sel   = 1'b1;
        wdata = '0;
        tick(4);

        // Reset state: live levels, no flags
        read_status(v);
        chk("R7 levels during reset", v, 16'hF700);
        chk("R11 req in reset", {12'h0, req}, 16'h0000);
        read_ctrl(v);
        chk("R1 ctrl reset", v, 16'h0000);

        // Leave reset: pin3 low, default low-level mode
        rst = 1'b0;
        tick(1);
        read_status(v);
        chk("R2 low level after reset", v, 16'hF708);
        chk("R11 req mirrors flag", {12'h0, req}, 16'h0008);

        // Control register layout
        reg_write(1'b0, 16'hABCD);
        read_ctrl(v);
        chk("R1 ctrl readback", v, 16'h00CD);

        // Table walk over all modes and transitions
        for (int i = 0; i < 16; i++) begin
            int          p;
            logic [1:0]  md;
            logic [15:0] c;
            p  = i % 4;
            md = VEC[i][4:3];
            reg_write(1'b0, 16'h00AA);
            pins    = 4'hF;
            pins[p] = VEC[i][2];
            tick(4);
            reg_write(1'b1, 16'h0000);
            c = 16'h00AA;
            c[2*p +: 2] = md;
            reg_write(1'b0, c);
            pins[p] = VEC[i][1];
            tick(5);
            read_status(v);
            case (md)
                2'b00:   chk("R2 table", {15'h0, v[p]}, {15'h0, VEC[i][0]});
                2'b01:   chk("R3 table", {15'h0, v[p]}, {15'h0, VEC[i][0]});
                2'b10:   chk("R4 table", {15'h0, v[p]}, {15'h0, VEC[i][0]});
                default: chk("R5 table", {15'h0, v[p]}, {15'h0, VEC[i][0]});
            endcase
            chk("R6 level bit", {15'h0, v[8+p]}, {15'h0, VEC[i][1]});
            chk("R11 req", {15'h0, req[p]}, {15'h0, VEC[i][0]});
        end

        // Status frame with everything quiet
        reg_write(1'b0, 16'h00AA);
        pins = 4'hF;
        tick(4);
        reg_write(1'b1, 16'h0000);
        read_status(v);
        chk("R6 quiet frame", v, 16'hFF00);

        // Latency of level and flag (rising mode, pin2)
        pins[2] = 1'b0;
        tick(4);
        reg_write(1'b1, 16'h0000);
        pins[2] = 1'b1;
        tick(1);
        read_status(v);
        chk("R7 level after one edge", {15'h0, v[10]}, 16'h0000);
        tick(1);
        read_status(v);
        chk("R7 level after two edges", {15'h0, v[10]}, 16'h0001);
        chk("R12 flag not yet", {15'h0, v[2]}, 16'h0000);
        tick(1);
        read_status(v);
        chk("R12 flag after three edges", {15'h0, v[2]}, 16'h0001);

        // Write-1 no effect, write-0 clears
        reg_write(1'b1, 16'hFFFF);
        read_status(v);
        chk("R8 write one keeps flag", v, 16'hFF04);
        reg_write(1'b1, 16'hFFFB);
        read_status(v);
        chk("R8 write zero clears", v, 16'hFF00);
        reg_write(1'b1, 16'h000F);
        read_status(v);
        chk("R8 write one no set", v, 16'hFF00);

        // Event wins over clear (both-edge mode, pin0)
        reg_write(1'b0, 16'h00AB);
        pins[0] = 1'b0;
        tick(4);
        read_status(v);
        chk("R5 falling in both mode", {15'h0, v[0]}, 16'h0001);
        pins[0] = 1'b1;
        tick(1);
        reg_write(1'b1, 16'h0000);
        read_status(v);
        chk("R9 event beats clear", {15'h0, v[0]}, 16'h0001);
        reg_write(1'b1, 16'h0000);
        read_status(v);
        chk("R8 clear without event", v, 16'hFF00);

        // Low-level clear override (pin1)
        reg_write(1'b0, 16'h00A2);
        pins[1] = 1'b0;
        tick(4);
        reg_write(1'b1, 16'h0000);
        read_status(v);
        chk("R2 clear overridden while low", v, 16'hFD02);
        pins[1] = 1'b1;
        tick(4);
        reg_write(1'b1, 16'h0000);
        read_status(v);
        chk("R2 clear once high", v, 16'hFF00);

        // Mode changes do not touch flags; history keeps tracking
        reg_write(1'b0, 16'h00A9);
        pins[0] = 1'b0;
        tick(4);
        reg_write(1'b0, 16'h00AA);
        read_status(v);
        chk("R10 mode change keeps flag", v, 16'hFE01);
        reg_write(1'b1, 16'h0000);
        reg_write(1'b0, 16'h00A9);
        tick(4);
        read_status(v);
        chk("R10 no stale edge after switch", v, 16'hFE00);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule